// File: doc/BRIEF.md
# Periodic Tick Timer

The block is a down-counting periodic timer that software programs through four 32-bit registers to raise a regular tick interrupt. A 24-bit counter steps once for each pulse on one of two tick-enable inputs. One pulse input comes from a slow reference clock and the other from the processor clock, and a control bit picks which one is used. When the counter falls from one to zero, a sticky count flag is set and, if enabled, a one-cycle interrupt pulse goes out. On the next pulse the counter reloads and the period starts again.

The block sits on a simple register bus with address, read and write strobes, write data and a privilege attribute. It answers with registered read data and an error bit. Unprivileged accesses are refused. Reading the control word clears the count flag. Writing the current-value word zeroes the counter and clears the flag. A zero reload value makes the timer stop at its next expiry while the enable bit stays set.

Top module: `tick_timer`

## Requirements
- R1: After reset the control word, the reload value and the counter all read as zero.
- R2: The reload register keeps only write-data bits [23:0]; higher bits read back as zero.
- R3: A write to control (offset 0x0) changes only bit 0 (run), bit 1 (interrupt enable) and bit 2 (source select). The count flag at bit 16 is never set by write data.
- R4: A read of control returns the count flag in bit 16 and then clears it, so a second read shows it clear.
- R5: While running, the counter steps on pulses of the selected input only: the processor pulse when bit 2 is 1, the reference pulse when it is 0. A pulse taken at zero loads the reload value and does not count as an expiry.
- R6: Offset 0xC reads as the constant 10000. Read data and the error bit appear in the cycle after the strobe.
- R7: Any write to the current-value register (offset 0x8) zeroes the counter and clears the count flag. The next selected pulse then loads the reload value.
- R8: An access with the privilege input low returns error = 1 with read data 0, and it changes no register and no flag.
- R9: With the run bit clear, the counter holds its value across pulses.
- R10: A step from 1 to 0 sets the count flag. It also gives a single-cycle interrupt pulse one cycle after the tick, but only if bit 1 is set.
- R11: An expiry while the reload value is zero halts counting with the run bit still set. The counter then ignores pulses, even after a new reload value is written, until the run bit rises again.
- R12: Offsets other than 0x0, 0x4, 0x8 and 0xC read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the register |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_priv | input | 1 | High for a privileged access |
| bus_rdata | output | 32 | Read data, registered |
| bus_err | output | 1 | Error response, registered |
| ref_tick | input | 1 | Tick enable from the reference clock |
| cpu_tick | input | 1 | Tick enable from the processor clock |
| irq_pulse | output | 1 | One-cycle tick interrupt |

## Verification
Read data and the error bit are due one cycle after the strobe edge. The counter, the flag and the interrupt change at the same edge that samples a tick pulse. The bench drives inputs on falling edges. A monitor records which accesses were on the bus at each rising edge and compares one nanosecond later against the queued expected word. The counter value and the flag are always observed through a later register read, so their one-edge latency is covered before the sample. Interrupt pulses are counted at the same offset after each rising edge and checked once every pulse sequence has completed.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    localparam int DATA_W   = 32;
    localparam int FLAG_BIT = 16;

    typedef enum logic [1:0] {
        SEL_CTRL    = 2'd0,
        SEL_RELOAD  = 2'd1,
        SEL_CURRENT = 2'd2,
        SEL_CALIB   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic use_cpu;
        logic irq_en;
        logic run;
    } ctrl_t;

    typedef struct packed {
        logic     hit;
        reg_sel_e sel;
    } decode_t;

    function automatic logic [DATA_W-1:0] ctrl_word(ctrl_t c, logic flag);
        logic [DATA_W-1:0] w;
        w = '0;
        w[2:0] = c;
        w[FLAG_BIT] = flag;
        return w;
    endfunction

endpackage

// File: rtl/tick_timer_regs.sv
module tick_timer_regs
    import tick_timer_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W = 24,
    parameter int CALIB_VALUE = 10000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              priv,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              expire,
    output logic [DATA_W-1:0] rdata,
    output logic              err,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  reload,
    output logic              cur_wr,
    output logic              en_rise,
    output logic              flag,
    output logic              irq
);
    localparam int PAD_W = DATA_W - CNT_W;

    function automatic decode_t decode(input logic [ADDR_W-1:0] a);
        decode_t d;
        d.hit = (a[1:0] == 2'b00) && (a[ADDR_W-1:4] == '0);
        d.sel = reg_sel_e'(a[3:2]);
        return d;
    endfunction

    function automatic logic [CNT_W-1:0] low_bits(input logic [DATA_W-1:0] w);
        return w[CNT_W-1:0];
    endfunction

    decode_t dec;
    logic    rd_ok, wr_ok, ctrl_wr, ctrl_rd, reload_wr;
    logic [DATA_W-1:0] rd_mux;

    always_comb begin
        dec       = decode(addr);
        rd_ok     = rd && priv && dec.hit;
        wr_ok     = wr && priv && dec.hit;
        ctrl_wr   = wr_ok && (dec.sel == SEL_CTRL);
        ctrl_rd   = rd_ok && (dec.sel == SEL_CTRL);
        reload_wr = wr_ok && (dec.sel == SEL_RELOAD);
        cur_wr    = wr_ok && (dec.sel == SEL_CURRENT);
        en_rise   = ctrl_wr && wdata[0] && !ctrl.run;
        case (dec.sel)
            SEL_CTRL:    rd_mux = ctrl_word(ctrl, flag);
            SEL_RELOAD:  rd_mux = {{PAD_W{1'b0}}, reload};
            SEL_CURRENT: rd_mux = {{PAD_W{1'b0}}, cnt};
            default:     rd_mux = DATA_W'(CALIB_VALUE);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            reload <= '0;
            flag   <= 1'b0;
            irq    <= 1'b0;
            rdata  <= '0;
            err    <= 1'b0;
        end else begin
            if (ctrl_wr)
                ctrl <= ctrl_t'(wdata[2:0]);
            if (reload_wr)
                reload <= low_bits(wdata);
            if (expire)
                flag <= 1'b1;
            else if (ctrl_rd || cur_wr)
                flag <= 1'b0;
            irq   <= expire && ctrl.irq_en;
            err   <= (rd || wr) && !priv;
            rdata <= rd_ok ? rd_mux : '0;
        end
    end

    a_r8_no_side_effect: assert property (@(posedge clk) disable iff (rst)
        ((rd || wr) && !priv) |=> ($stable(reload) && $stable(ctrl) && err));
    a_r3_flag_only_on_expiry: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(expire));
    a_r10_irq_single: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);
    a_r10_irq_with_flag: assert property (@(posedge clk) disable iff (rst)
        irq |-> flag);

endmodule

// File: rtl/tick_timer_counter.sv
module tick_timer_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             run,
    input  logic [CNT_W-1:0] reload,
    input  logic             cur_wr,
    input  logic             en_rise,
    output logic [CNT_W-1:0] cnt,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic halted;
    logic step;
    logic reload_zero;

    always_comb begin
        reload_zero = (reload == '0);
        step        = run && tick && !halted && !cur_wr;
        expire      = step && (cnt == ONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            halted <= 1'b0;
        end else if (cur_wr) begin
            cnt <= '0;
            if (reload_zero)
                halted <= 1'b1;
        end else begin
            if (en_rise)
                halted <= 1'b0;
            if (step) begin
                if (cnt == '0) begin
                    cnt <= reload;
                end else begin
                    cnt <= cnt - ONE;
                    if ((cnt == ONE) && reload_zero)
                        halted <= 1'b1;
                end
            end
        end
    end

    a_r9_hold_when_stopped: assert property (@(posedge clk) disable iff (rst)
        (!run && !cur_wr) |=> $stable(cnt));
    a_r7_cur_write_zeroes: assert property (@(posedge clk) disable iff (rst)
        cur_wr |=> (cnt == '0));
    a_r11_halt_holds: assert property (@(posedge clk) disable iff (rst)
        (halted && !en_rise && !cur_wr) |=> $stable(cnt));

endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W = 24,
    parameter int CALIB_VALUE = 10000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_priv,
    output logic [31:0]       bus_rdata,
    output logic              bus_err,
    input  logic              ref_tick,
    input  logic              cpu_tick,
    output logic              irq_pulse
);
    ctrl_t            ctrl;
    logic [CNT_W-1:0] reload, cnt;
    logic             cur_wr, en_rise, flag, expire, tick_sel;

    assign tick_sel = ctrl.use_cpu ? cpu_tick : ref_tick;

    tick_timer_regs #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .CALIB_VALUE(CALIB_VALUE)
    ) u_regs (
        .clk(clk), .rst(rst), .addr(bus_addr), .rd(bus_rd), .wr(bus_wr),
        .wdata(bus_wdata), .priv(bus_priv), .cnt(cnt), .expire(expire),
        .rdata(bus_rdata), .err(bus_err), .ctrl(ctrl), .reload(reload),
        .cur_wr(cur_wr), .en_rise(en_rise), .flag(flag), .irq(irq_pulse)
    );

    tick_timer_counter #(.CNT_W(CNT_W)) u_counter (
        .clk(clk), .rst(rst), .tick(tick_sel), .run(ctrl.run),
        .reload(reload), .cur_wr(cur_wr), .en_rise(en_rise),
        .cnt(cnt), .expire(expire)
    );

endmodule

// File: tb/test_tick_timer.sv
module test_tick_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0, bus_priv = 1'b1;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic        ref_tick = 1'b0, cpu_tick = 1'b0;
    logic        irq_pulse;

    int total = 0;
    int bad = 0;
    int irq_seen = 0;
    logic [33:0] exp_q[$];
    string       tag_q[$];
    bit          done = 0;

    localparam logic [7:0] A_CTRL = 8'h00, A_RLD = 8'h04, A_CUR = 8'h08, A_CAL = 8'h0C;

    always #2 clk = ~clk;

    tick_timer i_tick_timer (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_priv(bus_priv), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .ref_tick(ref_tick), .cpu_tick(cpu_tick), .irq_pulse(irq_pulse)
    );

    // Monitor: pops one expected item per bus access, compares 1 ns after the edge.
    always @(posedge clk) begin
        if (!rst && (bus_rd || bus_wr)) begin
            #1;
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL scoreboard: access with nothing expected");
            end else begin
                logic [33:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                total++;
                if (bus_err !== e[32] || (e[33] && bus_rdata !== e[31:0])) begin
                    bad++;
                    $display("FAIL %s: actual err=%0b data=0x%08h expected err=%0b data=0x%08h",
                             t, bus_err, bus_rdata, e[32], e[31:0]);
                end
            end
        end
    end

    always @(posedge clk) begin
        #1;
        if (!rst && irq_pulse === 1'b1) irq_seen++;
    end

    task automatic access(input logic [7:0] a, input bit is_rd, input bit priv,
                          input logic [31:0] wd, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a; bus_rd = is_rd; bus_wr = !is_rd; bus_priv = priv; bus_wdata = wd;
        exp_q.push_back({is_rd, !priv, priv ? exp : 32'h0});
        tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0; bus_priv = 1'b1;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        access(a, 1'b1, 1'b1, '0, exp, tag);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        access(a, 1'b0, 1'b1, d, '0, "write");
    endtask

    task automatic pulse(input bit use_cpu, input int n);
        repeat (n) begin
            @(negedge clk);
            if (use_cpu) cpu_tick = 1'b1; else ref_tick = 1'b1;
            @(negedge clk);
            cpu_tick = 1'b0; ref_tick = 1'b0;
        end
    endtask

    task automatic check_irq(input int exp, input string tag);
        total++;
        if (irq_seen != exp) begin
            bad++;
            $display("FAIL %s: actual irq count=%0d expected=%0d", tag, irq_seen, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 / R6: reset state and calibration
        rd(A_CTRL, 32'h0, "R1 ctrl");
        rd(A_RLD, 32'h0, "R1 reload");
        rd(A_CUR, 32'h0, "R1 counter");
        rd(A_CAL, 32'd10000, "R6 calib");
        // R2: truncation
        wr(A_RLD, 32'hAB00_0005);
        rd(A_RLD, 32'h5, "R2 reload width");
        // R3: only low three bits written
        wr(A_CTRL, 32'hFFFF_FFFB);
        rd(A_CTRL, 32'h3, "R3 ctrl bits");
        // R5: wrong source ignored, load on pulse at zero
        pulse(1, 3);
        rd(A_CUR, 32'h0, "R5 other source ignored");
        pulse(0, 1);
        rd(A_CUR, 32'h5, "R5 load");
        check_irq(0, "R5 load not expiry");
        pulse(0, 4);
        rd(A_CUR, 32'h1, "R5 decrement");
        rd(A_CTRL, 32'h3, "R10 no flag before expiry");
        pulse(0, 1);
        check_irq(1, "R10 irq on expiry");
        rd(A_CUR, 32'h0, "R10 counter at zero");
        // R8: unprivileged
        access(A_CTRL, 1'b1, 1'b0, '0, '0, "R8 unpriv read");
        access(A_RLD, 1'b0, 1'b0, 32'h9, '0, "R8 unpriv write");
        rd(A_RLD, 32'h5, "R8 reload unchanged");
        // R4: read clears flag
        rd(A_CTRL, 32'h0001_0003, "R4 flag seen");
        rd(A_CTRL, 32'h3, "R4 flag cleared");
        // R7: current-value write
        pulse(0, 6);
        check_irq(2, "R10 second expiry");
        pulse(0, 3);
        wr(A_CUR, 32'h1234);
        rd(A_CUR, 32'h0, "R7 counter zeroed");
        rd(A_CTRL, 32'h3, "R7 flag cleared");
        pulse(0, 1);
        rd(A_CUR, 32'h5, "R7 reload after clear");
        // R9: freeze
        wr(A_CTRL, 32'h2);
        pulse(0, 3);
        rd(A_CUR, 32'h5, "R9 frozen");
        check_irq(2, "R9 no irq while stopped");
        // R10: interrupt disabled
        wr(A_CTRL, 32'h1);
        pulse(0, 5);
        check_irq(2, "R10 irq masked");
        rd(A_CTRL, 32'h0001_0001, "R10 flag without irq");
        // R5: processor source
        wr(A_CTRL, 32'h5);
        pulse(0, 2);
        rd(A_CUR, 32'h0, "R5 reference ignored");
        pulse(1, 3);
        rd(A_CUR, 32'h3, "R5 processor source");
        // R11: zero reload stop
        wr(A_RLD, 32'h0);
        pulse(1, 3);
        rd(A_CTRL, 32'h0001_0005, "R11 run stays set");
        wr(A_RLD, 32'h7);
        pulse(1, 2);
        rd(A_CUR, 32'h0, "R11 halted");
        wr(A_CTRL, 32'h4);
        wr(A_CTRL, 32'h5);
        pulse(1, 1);
        rd(A_CUR, 32'h7, "R11 restart");
        // R12: unmapped offsets
        rd(8'h10, 32'h0, "R12 unmapped read");
        rd(8'h06, 32'h0, "R12 misaligned read");
        wr(8'h10, 32'hFFFF_FFFF);
        rd(A_RLD, 32'h7, "R12 reload untouched");
        rd(A_CTRL, 32'h5, "R12 ctrl untouched");
        repeat (3) @(negedge clk);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule